// File: doc/BRIEF.md
# Dual-Mode Full-Bridge Gate Generator

This block drives the eight gate-level signals of an isolated converter built from two H-bridges, four switches on the primary side and four on the secondary side. One free-running counter, measured in system clock cycles, defines the switching period. A mode input selects between pulse-width modulation, where the two diagonal pairs of the primary bridge conduct in alternate half periods, and phase-shift modulation, where each primary leg runs at a fixed 50% and the second leg trails the first by a programmable number of cycles.

A single duty word serves both modes: it is the on-time of each diagonal in PWM mode and the lag between legs in phase-shift mode. The block saturates that word below half a period, so the primary bridge can never short its supply and the secondary bridge can never open the inductor path. Each secondary gate is the inverse of the matching primary gate. Mode, duty and period take effect only at a period boundary, so a change in the middle of a period never produces a runt pulse.

Top module: `fb_gate_gen`

## Requirements
- R1: While rst_ni is low, all eight outputs gate_p_o and gate_s_o are low.
- R2: Out of reset, gate_s_o[k] is the inverse of gate_p_o[k] for every k (bit k drives switch k+1 of its bridge).
- R3: In PWM mode (mode_i = 0), with count c running 0 to P-1, H = floor(P/2) and clamped duty D, gate_p_o bits 0 and 3 are high for c < D and bits 1 and 2 are high for H <= c < H+D; both diagonals are never on together.
- R4: In phase-shift mode (mode_i = 1), bit 0 is high for c < H and bit 1 is its inverse; bit 2 is high for D <= c < D+H and bit 3 is its inverse.
- R5: The duty in use is duty_i when duty_i < H, otherwise H-1.
- R6: A period_i below 4 is used as 4.
- R7: mode_i, duty_i and period_i are sampled only at the clock edge that ends the current period (count P-1); values applied at other edges do not change the current period.
- R8: Outputs are registered: the outputs after an edge reflect the count held before it. The first period after reset is 4 cycles long in PWM mode with duty 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 selects PWM, 1 selects phase shift |
| duty_i | input | CNT_W | Duty in clock cycles (on-time or leg lag) |
| period_i | input | CNT_W | Switching period in clock cycles |
| gate_p_o | output | 4 | Primary bridge gates, bit k drives switch k+1 |
| gate_s_o | output | 4 | Secondary bridge gates, bit k drives switch k+5 |

## Verification
The parameter reload and the counter wrap land on the same edge, and the last count of a period is output in that cycle too. The bench drives new mode, duty and period values in every possible phase of the running period, including the final count, while an independent cycle model decides which values must govern each period. Every output cycle is compared against that model, so a reload taken one cycle early or late, or a wrap that misaligns with the reload, shows up as a mismatch on the first differing gate.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  typedef enum logic {
    MODE_PWM = 1'b0,
    MODE_PSM = 1'b1
  } fbg_mode_e;

  localparam int unsigned FBG_MIN_PERIOD = 4;
  localparam int unsigned FBG_GATES      = 4;
endpackage

// File: rtl/fbg_shadow.sv
module fbg_shadow
  import fbg_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MIN_PER = FBG_MIN_PERIOD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] period_i,
  output fbg_mode_e        mode_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] half_o,
  output logic [CNT_W-1:0] duty_o
);
  localparam logic [CNT_W-1:0] PMIN = CNT_W'(MIN_PER);

  logic [CNT_W-1:0] per_c, half_c, duty_c;

  // period floor, then duty saturates one cycle below half
  always_comb begin
    per_c  = (period_i < PMIN) ? PMIN : period_i;
    half_c = per_c >> 1;
    duty_c = (duty_i >= half_c) ? (half_c - CNT_W'(1)) : duty_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_PWM;
      per_o  <= PMIN;
      half_o <= PMIN >> 1;
      duty_o <= '0;
    end else if (load_i) begin
      mode_o <= fbg_mode_e'(mode_i);
      per_o  <= per_c;
      half_o <= half_c;
      duty_o <= duty_c;
    end
  end

  AST_DUTY_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_o < half_o); // R5
  AST_PER_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_o >= PMIN); // R6
  AST_HOLD_MIDPERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(duty_o) && $stable(per_o) && $stable(mode_o))); // R7
endmodule

// File: rtl/fbg_counter.sv
module fbg_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  assign last_o = (cnt_o == per_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (last_o) cnt_o <= '0;
    else             cnt_o <= cnt_o + CNT_W'(1);
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o < per_i); // R6
endmodule

// File: rtl/fbg_wave.sv
module fbg_wave
  import fbg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  fbg_mode_e            mode_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [CNT_W-1:0]     half_i,
  input  logic [CNT_W-1:0]     duty_i,
  output logic [FBG_GATES-1:0] gate_o
);
  logic diag_a, diag_b, leg_a, leg_b;

  always_comb begin
    diag_a = cnt_i < duty_i;
    diag_b = (cnt_i >= half_i) && ((cnt_i - half_i) < duty_i);
    leg_a  = cnt_i < half_i;
    leg_b  = (cnt_i >= duty_i) && ((cnt_i - duty_i) < half_i);
  end

  always_comb begin
    unique case (mode_i)
      MODE_PWM: gate_o = {diag_a, diag_b, diag_b, diag_a};
      MODE_PSM: gate_o = {~leg_b, leg_b, ~leg_a, leg_a};
      default:  gate_o = '0;
    endcase
  end

  AST_PWM_NO_SHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PWM) |-> !(gate_o[0] && gate_o[1])); // R3
  AST_PSM_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PSM && cnt_i == duty_i) |-> gate_o[2]); // R4
endmodule

// File: rtl/fb_gate_gen.sv
module fb_gate_gen
  import fbg_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MIN_PER = FBG_MIN_PERIOD
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_i,
  input  logic [CNT_W-1:0]     duty_i,
  input  logic [CNT_W-1:0]     period_i,
  output logic [FBG_GATES-1:0] gate_p_o,
  output logic [FBG_GATES-1:0] gate_s_o
);
  fbg_mode_e            mode_q;
  logic [CNT_W-1:0]     per_q, half_q, duty_q, cnt;
  logic                 last;
  logic [FBG_GATES-1:0] gate_d;
  logic                 out_vld_q;

  fbg_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .per_i  (per_q),
    .cnt_o  (cnt),
    .last_o (last)
  );

  fbg_shadow #(.CNT_W(CNT_W), .MIN_PER(MIN_PER)) i_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (last),
    .mode_i   (mode_i),
    .duty_i   (duty_i),
    .period_i (period_i),
    .mode_o   (mode_q),
    .per_o    (per_q),
    .half_o   (half_q),
    .duty_o   (duty_q)
  );

  fbg_wave #(.CNT_W(CNT_W)) i_wave (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_q),
    .cnt_i  (cnt),
    .half_i (half_q),
    .duty_i (duty_q),
    .gate_o (gate_d)
  );

  // all gates low in reset; secondary is the inverse afterwards
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_p_o  <= '0;
      gate_s_o  <= '0;
      out_vld_q <= 1'b0;
    end else begin
      gate_p_o  <= gate_d;
      gate_s_o  <= ~gate_d;
      out_vld_q <= 1'b1;
    end
  end

  AST_SEC_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_q |-> (gate_s_o == ~gate_p_o)); // R2
endmodule

// File: tb/test_fb_gate_gen.sv
module test_fb_gate_gen;
  localparam int unsigned CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             mode_i = 1'b0;
  logic [CNT_W-1:0] duty_i = '0;
  logic [CNT_W-1:0] period_i = '0;
  logic [3:0]       gate_p_o, gate_s_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  // independent reference state
  int rc, r_per, r_half, r_duty;
  bit r_mode;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fb_gate_gen #(.CNT_W(CNT_W)) i_fb_gate_gen (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .duty_i   (duty_i),
    .period_i (period_i),
    .gate_p_o (gate_p_o),
    .gate_s_o (gate_s_o)
  );

  typedef struct packed {
    logic        mode;
    logic [15:0] per;
    logic [15:0] duty;
    logic [15:0] cycles;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'd20,  16'd5,   16'd60},
    '{1'b0, 16'd21,  16'd7,   16'd63},
    '{1'b0, 16'd20,  16'd15,  16'd50},
    '{1'b1, 16'd20,  16'd5,   16'd57},
    '{1'b1, 16'd17,  16'd3,   16'd51},
    '{1'b1, 16'd10,  16'd200, 16'd33},
    '{1'b0, 16'd2,   16'd1,   16'd20},
    '{1'b1, 16'd0,   16'd0,   16'd20},
    '{1'b1, 16'd9,   16'd0,   16'd27},
    '{1'b0, 16'd64,  16'd31,  16'd150}
  };

  function automatic logic [3:0] ref_wave(int c, bit m, int d, int h);
    bit a, b;
    if (!m) begin
      a = c < d;
      b = (c >= h) && (c < h + d);
      return {a, b, b, a};
    end
    a = c < h;
    b = (c >= d) && (c < d + h);
    return {~b, b, ~a, a};
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic ref_reset();
    rc = 0; r_per = 4; r_half = 2; r_duty = 0; r_mode = 1'b0;
  endtask

  task automatic ref_load();
    int p;
    p = (int'(period_i) < 4) ? 4 : int'(period_i);
    r_per  = p;
    r_half = p / 2;
    r_duty = (int'(duty_i) >= r_half) ? r_half - 1 : int'(duty_i);
    r_mode = mode_i;
  endtask

  // one clock; compare after the edge against the model
  task automatic step(string tag);
    logic [3:0] exp;
    exp = ref_wave(rc, r_mode, r_duty, r_half);
    @(posedge clk);
    @(negedge clk);
    check(tag, gate_p_o, exp);
    check("R2", gate_s_o, ~exp);
    if (rc == r_per - 1) begin
      rc = 0;
      ref_load();
    end else rc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R1", gate_p_o, 4'b0000);
      check("R1", gate_s_o, 4'b0000);
    end
    rst_ni = 1'b1;
    ref_reset();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int hi;
    // R1: outputs low during reset
    mode_i = 1'b1; duty_i = 16'd3; period_i = 16'd12;
    do_reset();
    // R8: first period is 4 cycles of PWM with duty 0
    for (int i = 0; i < 4; i++) step("R8");
    for (int i = 0; i < 30; i++) step("R7");

    // vector walk; inputs change in arbitrary period phases (R7)
    for (int v = 0; v < NV; v++) begin
      mode_i   = VECS[v].mode;
      duty_i   = VECS[v].duty;
      period_i = VECS[v].per;
      for (int k = 0; k < int'(VECS[v].cycles); k++)
        step(VECS[v].mode ? "R4" : "R3");
    end

    // R5: duty above half saturates to half-1, counted over one period
    mode_i = 1'b0; period_i = 16'd30; duty_i = 16'd100;
    for (int i = 0; i < 80; i++) step("R5");
    hi = 0;
    for (int i = 0; i < 30; i++) begin step("R5"); hi += gate_p_o[0]; end
    n_chk++;
    if (hi != 14) begin n_err++; $display("FAIL R5: actual %0d expected 14", hi); end

    // R6: period 1 runs as 4; PSM leg at 50%
    mode_i = 1'b1; period_i = 16'd1; duty_i = 16'd0;
    for (int i = 0; i < 40; i++) step("R6");
    hi = 0;
    for (int i = 0; i < 40; i++) begin step("R6"); hi += gate_p_o[0]; end
    n_chk++;
    if (hi != 20) begin n_err++; $display("FAIL R6: actual %0d expected 20", hi); end

    // R7: duty change on the final count and mid-period
    mode_i = 1'b0; period_i = 16'd16; duty_i = 16'd2;
    for (int i = 0; i < 40; i++) step("R7");
    while (rc != 15) step("R7");
    duty_i = 16'd6;
    for (int i = 0; i < 20; i++) step("R7");
    while (rc != 5) step("R7");
    duty_i = 16'd1; mode_i = 1'b1; period_i = 16'd8;
    for (int i = 0; i < 40; i++) step("R7");

    // R1/R8: reset mid-run, then restart
    do_reset();
    for (int i = 0; i < 12; i++) step("R8");

    finish_run();
  end
endmodule